// File: doc/BRIEF.md
# Page-Buffered Write Sequencer

This block is the write side of a byte-wide non-volatile memory model that is programmed a whole page at a time. A host presents an address and a data byte on a synchronous write strobe. Each accepted byte goes into a 128-entry page buffer. The load phase has no commit command. It stays open while bytes keep arriving within a quiet-time window, and it closes on its own once the window passes with no new byte. A timed program cycle then copies the entire page into the storage array in one step. Every slot that was not loaded in that phase is written as FFh.

A write counts only when the select input and the write strobe are high and the output-enable input is low. The qualified strobe must also stay high for a minimum number of consecutive cycles, which filters out glitches. Bytes aimed at a different page than the one that opened the phase are dropped, and a one-cycle error pulse flags each of them. Any write that arrives while programming is in progress is discarded. The timeout, the program length, the glitch width and the address width are parameters. Simulation can therefore use short timings, and the array can scale up to the full 64K x 8 layout (address width 16).

A combinational read port exposes the array contents. Outputs also report the busy state and the address and data of the last byte that was accepted.

Top module: `pgwr_seq`

## Requirements
- R1: Address bits [ADDR_W-1:7] choose the page and bits [6:0] choose the byte slot inside it. A committed byte appears at exactly the address it was loaded with.
- R2: Slots may be loaded in any order, and each slot lands at its own position.
- R3: Every accepted byte of the open page restarts a window of LOAD_TMO cycles. When LOAD_TMO clock edges pass with no such byte, busy rises at that edge.
- R4: Any slot of the page not loaded in the current phase is programmed to FFh.
- R5: busy stays high for exactly PROG_CYC cycles. The array keeps its old contents until the edge on which busy falls, and at that edge all 128 bytes of the page change together.
- R6: Writes presented while busy is high are discarded. They do not change last_addr or last_data, and they never reach the array.
- R7: A write is accepted only with ce=1, we=1 and oe=0. With oe=1 or ce=0 nothing is loaded.
- R8: The qualified strobe must stay high for GLITCH_CYC consecutive cycles. A shorter pulse is ignored, and a longer pulse is accepted once, on its GLITCH_CYC-th cycle.
- R9: During a load phase, a byte whose page differs from the opening byte's page is ignored. It raises err for the single cycle after its accepting edge.
- R10: The buffer is cleared at the start of every load phase, so bytes loaded in an earlier phase never reach a later program.
- R11: Loading the same slot twice in one phase keeps the most recent data.
- R12: After reset, busy=0, err=0, last_addr=0, last_data=0, and every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Device select, active high |
| we | input | 1 | Write strobe, active high |
| oe | input | 1 | Output enable, active high; inhibits writes |
| addr | input | ADDR_W | Write address (page and slot) |
| wdata | input | 8 | Write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |
| busy | output | 1 | Program cycle in progress |
| err | output | 1 | One-cycle pulse for a dropped foreign-page byte |
| last_addr | output | ADDR_W | Address of the last accepted byte |
| last_data | output | 8 | Data of the last accepted byte |

## Verification
The hardest situation to reach is the one that checks R10. Bytes left in the buffer from an earlier phase must not survive into a second program of the same page. To reach it, the stimulus loads page 3 with several slots and lets it commit. It then reopens page 3 with a single different slot, so a stale slot that reappears in the array exposes a missed clear. The same first phase also mixes in a foreign-page byte, a repeated slot and a write issued during busy, so that R9, R11 and R6 all meet within one program cycle. Byte spacing close to the timeout, kept just under it, exercises the R3 window restart.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    localparam int BYTE_W     = 8;
    localparam int SLOT_BITS  = 7;
    localparam int PAGE_BYTES = 1 << SLOT_BITS;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;

    typedef struct packed {
        logic [SLOT_BITS-1:0] slot;
        byte_t                data;
    } slot_wr_t;

    function automatic byte_t erased_byte();
        return byte_t'(8'hFF);
    endfunction
endpackage

// File: rtl/pgwr_strobe.sv
module pgwr_strobe #(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic we,
    input  logic oe,
    output logic take
);
    localparam int RW = $clog2(GLITCH_CYC + 1);

    logic          qual;
    logic [RW-1:0] run;

    assign qual = ce & we & ~oe;
    assign take = qual && (run == RW'(GLITCH_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst)                         run <= '0;
        else if (!qual)                  run <= '0;
        else if (run != RW'(GLITCH_CYC)) run <= run + 1'b1;
    end

    generate
        if (GLITCH_CYC > 1) begin : g_width_chk
            // R8: an accepted strobe was already qualified one cycle earlier
            p_min_width_r8: assert property (@(posedge clk) disable iff (rst)
                take |-> $past(qual));
        end
    endgenerate
endmodule

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf
    import pgwr_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            open_ph,
    input  logic                            wr,
    input  slot_wr_t                        w,
    output logic [PAGE_BYTES-1:0][BYTE_W-1:0] image
);
    byte_t                 data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) data[i] <= erased_byte();
        end else begin
            if (open_ph) begin
                valid <= '0;
                for (int i = 0; i < PAGE_BYTES; i++) data[i] <= erased_byte();
            end
            if (wr) begin
                data[w.slot]  <= w.data;
                valid[w.slot] <= 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_img
            assign image[g] = valid[g] ? data[g] : erased_byte();
        end
    endgenerate

    // R10: a newly opened phase holds at most its opening byte
    p_fresh_phase_r10: assert property (@(posedge clk) disable iff (rst)
        open_ph |=> ($countones(valid) <= 1));
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int PAGE_W   = 4,
    parameter int LOAD_TMO = 37500,
    parameter int PROG_CYC = 2500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [PAGE_W-1:0] page_in,
    output logic              open_ph,
    output logic              store,
    output logic              commit,
    output logic              busy,
    output logic              err,
    output logic [PAGE_W-1:0] page
);
    localparam int TW = $clog2(LOAD_TMO + 1);
    localparam int PW = $clog2(PROG_CYC + 1);

    phase_e        phase;
    logic [TW-1:0] tmr;
    logic [PW-1:0] pcnt;
    logic          same;

    assign same    = (page_in == page);
    assign open_ph = take && (phase == PH_IDLE);
    assign store   = take && ((phase == PH_IDLE) || ((phase == PH_LOAD) && same));
    assign busy    = (phase == PH_PROG);
    assign commit  = busy && (pcnt == PW'(PROG_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            tmr   <= '0;
            pcnt  <= '0;
            page  <= '0;
            err   <= 1'b0;
        end else begin
            err <= 1'b0;
            unique case (phase)
                PH_IDLE: if (take) begin
                    phase <= PH_LOAD;
                    page  <= page_in;
                    tmr   <= '0;
                end
                PH_LOAD: begin
                    if (store) begin
                        tmr <= '0;
                    end else begin
                        if (take) err <= 1'b1;
                        if (tmr == TW'(LOAD_TMO - 1)) begin
                            phase <= PH_PROG;
                            pcnt  <= '0;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                end
                PH_PROG: begin
                    if (commit) phase <= PH_IDLE;
                    else        pcnt  <= pcnt + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3: programming is only ever entered from an open load phase
    p_prog_from_load_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(phase) == PH_LOAD));
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int LOAD_TMO   = 37500,
    parameter int PROG_CYC   = 2500000,
    parameter int GLITCH_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              we,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              err,
    output logic [ADDR_W-1:0] last_addr,
    output logic [7:0]        last_data
);
    localparam int PAGE_W = ADDR_W - SLOT_BITS;
    localparam int DEPTH  = 1 << ADDR_W;

    logic                               take, open_ph, store, commit;
    logic [PAGE_W-1:0]                  page;
    logic [PAGE_BYTES-1:0][BYTE_W-1:0]  image;
    slot_wr_t                           wpkt;
    byte_t                              mem [DEPTH];

    assign wpkt.slot = addr[SLOT_BITS-1:0];
    assign wpkt.data = wdata;

    pgwr_strobe #(.GLITCH_CYC(GLITCH_CYC)) u_strobe (
        .clk(clk), .rst(rst), .ce(ce), .we(we), .oe(oe), .take(take)
    );

    pgwr_ctrl #(.PAGE_W(PAGE_W), .LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .take(take), .page_in(addr[ADDR_W-1:SLOT_BITS]),
        .open_ph(open_ph), .store(store), .commit(commit), .busy(busy),
        .err(err), .page(page)
    );

    pgwr_pagebuf u_buf (
        .clk(clk), .rst(rst), .open_ph(open_ph), .wr(store), .w(wpkt), .image(image)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= erased_byte();
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                mem[{page, SLOT_BITS'(i)}] <= image[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr <= '0;
            last_data <= '0;
        end else if (store) begin
            last_addr <= addr;
            last_data <= wdata;
        end
    end

    assign rd_data = mem[rd_addr];

    // R6: a strobe accepted during programming leaves the last-byte record alone
    p_busy_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && take) |=> ($stable(last_addr) && $stable(last_data)));

    // R9: an error pulse follows an accepted strobe outside programming
    p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(take) && !$past(busy)));
endmodule

// File: tb/pgwr_seq_test.sv
`timescale 1ns/100ps
module pgwr_seq_test;
    localparam int AW  = 11;
    localparam int TMO = 24;
    localparam int PC  = 40;
    localparam int GL  = 2;
    localparam int DEP = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce = 0, we = 0, oe = 0;
    logic [AW-1:0] addr = '0, rd_addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rd_data, last_data;
    logic [AW-1:0] last_addr;
    logic          busy, err;

    int n_chk = 0, n_fail = 0, cyc = 0;

    pgwr_seq #(.ADDR_W(AW), .LOAD_TMO(TMO), .PROG_CYC(PC), .GLITCH_CYC(GL)) uut (
        .clk(clk), .rst(rst), .ce(ce), .we(we), .oe(oe), .addr(addr), .wdata(wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .err(err),
        .last_addr(last_addr), .last_data(last_data)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference model
    int m_mem [DEP];
    int m_buf [128];
    int m_mode, m_quiet, m_left, m_page, m_hold, m_la, m_ld;
    bit m_err;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 'hFF;
            m_mode = 0; m_quiet = 0; m_left = 0; m_page = 0; m_hold = 0;
            m_la = 0; m_ld = 0; m_err = 0;
        end else begin
            bit q, tk;
            q  = ce && we && !oe;
            tk = q && (m_hold == GL - 1);
            m_hold = q ? ((m_hold < GL) ? m_hold + 1 : GL) : 0;
            m_err = 0;
            if (m_mode == 0) begin
                if (tk) begin
                    foreach (m_buf[i]) m_buf[i] = 'hFF;
                    m_page = int'(addr) / 128;
                    m_buf[int'(addr) % 128] = int'(wdata);
                    m_la = int'(addr); m_ld = int'(wdata);
                    m_quiet = 0; m_mode = 1;
                end
            end else if (m_mode == 1) begin
                if (tk && (int'(addr) / 128 == m_page)) begin
                    m_buf[int'(addr) % 128] = int'(wdata);
                    m_la = int'(addr); m_ld = int'(wdata);
                    m_quiet = 0;
                end else begin
                    if (tk) m_err = 1;
                    if (m_quiet == TMO - 1) begin m_mode = 2; m_left = 0; end
                    else m_quiet++;
                end
            end else begin
                if (m_left == PC - 1) begin
                    foreach (m_buf[i]) m_mem[m_page * 128 + i] = m_buf[i];
                    m_mode = 0;
                end else m_left++;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R3/R5 busy", int'(busy), int'(m_mode == 2));
            chk("R9 err", int'(err), int'(m_err));
            chk("R6/R11 last_addr", int'(last_addr), m_la);
            chk("R6/R11 last_data", int'(last_data), m_ld);
            chk("R4 rd_data", int'(rd_data), m_mem[int'(rd_addr)]);
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr(input int a, input int d, input int len, input bit c = 1'b1,
                      input bit o = 1'b0);
        @(negedge clk); #1;
        ce = c; we = 1'b1; oe = o; addr = AW'(a); wdata = 8'(d);
        repeat (len) @(negedge clk);
        #1; ce = 1'b0; we = 1'b0; oe = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input string tag, input int a, input int exp);
        @(negedge clk); #1;
        rd_addr = AW'(a);
        #0.2;
        chk(tag, int'(rd_data), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R12: reset state
        #0.2;
        chk("R12 busy", int'(busy), 0);
        chk("R12 err", int'(err), 0);
        chk("R12 last_addr", int'(last_addr), 0);
        chk("R12 last_data", int'(last_data), 0);
        peek("R12 array", 'h3A5, 'hFF);

        // page 3: out-of-order, repeat slot, foreign page mixed in
        wr('h185, 'h11, 2); idle(3);
        wr('h182, 'h22, 2); idle(3);
        wr('h205, 'h99, 2); idle(3);
        wr('h1E4, 'h33, 2); idle(3);
        wr('h185, 'h44, 2);
        idle(TMO + 4);
        chk("R5 busy during program", int'(busy), 1);
        peek("R5 array unchanged while busy", 'h185, 'hFF);
        wr('h186, 'h77, 3);
        idle(PC);
        chk("R5 busy cleared", int'(busy), 0);
        peek("R11 newest data kept", 'h185, 'h44);
        peek("R2 any order", 'h182, 'h22);
        peek("R1 page and slot bits", 'h1E4, 'h33);
        peek("R4 unloaded slot erased", 'h180, 'hFF);
        peek("R9 foreign byte dropped", 'h205, 'hFF);
        peek("R6 busy write dropped", 'h186, 'hFF);
        chk("R6 last_data", int'(last_data), 'h44);

        // R8: single-cycle pulse is a glitch
        wr('h300, 'h55, 1);
        idle(TMO + 4);
        chk("R8 glitch no busy", int'(busy), 0);
        chk("R8 glitch last_addr", int'(last_addr), 'h185);

        // R7: inhibited strobes
        wr('h301, 'h56, 3, 1'b0, 1'b0);
        wr('h302, 'h57, 3, 1'b1, 1'b1);
        idle(TMO + 4);
        chk("R7 inhibited no busy", int'(busy), 0);
        chk("R7 inhibited last_addr", int'(last_addr), 'h185);
        peek("R7 inhibited array", 'h302, 'hFF);

        // R10: reopen page 3 with one slot only
        wr('h182, 'h66, 2);
        idle(TMO + PC + 4);
        peek("R10 stale slot erased", 'h185, 'hFF);
        peek("R10 new slot written", 'h182, 'h66);

        // R3: spacing just inside the window keeps the phase open
        for (int k = 0; k < 4; k++) begin
            wr('h280 + k * 9, 'hA0 + k, 2);
            idle(TMO - 6);
        end
        chk("R3 window still open", int'(busy), 0);
        idle(PC + 10);
        for (int k = 0; k < 4; k++) peek("R3 spaced bytes", 'h280 + k * 9, 'hA0 + k);

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule